// File: doc/BRIEF.md
# Multiplexed SAR ADC Channel Controller

This block is an SPI master for a 4- or 8-input successive-approximation converter. The converter takes a 14-bit configuration word in every frame. The result it returns in any frame belongs to the configuration written two frames earlier. The controller keeps a shadow copy of that configuration word. A host asks for a channel with a single-cycle request. The controller patches only the channel-select field of the shadow and sends as many frames as the two-frame pipeline needs. It then hands back a right-aligned 14-bit or 16-bit sample with a one-cycle valid pulse.

After reset the controller writes a fixed start-up configuration and runs two throw-away conversions on channel 0, so the first host request sees a primed converter. A second host input replaces the whole configuration word and sends it in one frame. Each frame uses SPI mode 0 with 16 clock cycles, and a programmable idle gap follows it. The default gap is 500 system clocks, which is 2 µs at 250 MHz.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, busy_o is high and the block sends exactly 5 frames, each carrying the start-up word. In that word bit 13 = 1, bits 12:10 = 7, bits 9:7 = 0, bit 6 = 1, bits 5:3 = REF_SEL, bits 2:1 = 0 and bit 0 = 1. busy_o then falls with no res_valid_o pulse.
- R2: Each frame holds cs_no low for 16 sclk_o cycles. sclk_o idles low, mosi_o changes on falling edges and miso_i is sampled on rising edges. The frame sends the 14-bit configuration MSB first in the upper bits of the 16-bit frame, followed by two zero bits.
- R3: Between the rise of cs_no and the next fall of cs_no there are at least GAP_CYCLES system clocks.
- R4: A request for a channel other than the active one sends 3 frames. The result comes from the third frame and belongs to the requested channel.
- R5: A request for the active channel sends 2 frames, and the result comes from the second frame.
- R6: A request changes only bits 9:7 of the shadow configuration, which take the channel number in binary. The other 11 bits keep their value.
- R7: The last frame of a request carries the same configuration as the frame before it.
- R8: res_data_o equals the 16-bit word received in the last frame shifted right by 16 − RES. Bits RES and above are zero. res_valid_o lasts one cycle.
- R9: busy_o rises in the cycle after a request or write is accepted and falls together with res_valid_o, or when a write frame ends. While busy_o is high, requests and writes are ignored.
- R10: A full write replaces all 14 configuration bits and sends exactly one frame. The channel in its bits 9:7 becomes the active channel.
- R11: After a request's last frame, the requested channel becomes the active channel, so the next request for the same channel takes the 2-frame path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Conversion request strobe |
| req_ch_i | input | $clog2(NUM_CH) | Requested channel |
| cfg_wr_i | input | 1 | Full configuration write strobe |
| cfg_data_i | input | 14 | Configuration word for a full write |
| busy_o | output | 1 | Request or write in progress |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 16 | Right-aligned conversion result |
| sclk_o | output | 1 | SPI clock |
| cs_no | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | Serial configuration out |
| miso_i | input | 1 | Serial data in |

## Verification
The assertions assume that SCLK_DIV is even and at least 4, so mosi_o has settled for at least one system clock before every rising sclk_o edge. They also assume that req_valid_i and cfg_wr_i are plain synchronous strobes. The bench drives both strobes only away from the clock edge and uses SCLK_DIV = 4. It sets bit 13 in every full write, so the converter model always applies the word. It also pulses the strobes in the middle of a transaction to check that they are ignored. Channel numbers are drawn only from the valid range.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  localparam int CFG_W   = 14;
  localparam int FRAME_W = 16;
  localparam int CH_LSB  = 7;
  localparam int CH_FLD  = 3;

  typedef enum logic [1:0] {C_BOOT, C_IDLE, C_RUN, C_WRITE} ctrl_state_e;
  typedef enum logic [1:0] {F_IDLE, F_XFER, F_GAP} frame_state_e;

  function automatic logic [CFG_W-1:0] boot_cfg(input logic [2:0] ref_code);
    logic [CFG_W-1:0] w;
    w        = '0;
    w[13]    = 1'b1;      // apply update
    w[12:10] = 3'd7;      // unipolar, ground referenced
    w[6]     = 1'b1;      // full bandwidth
    w[5:3]   = ref_code;
    w[0]     = 1'b1;      // no readback
    return w;
  endfunction
endpackage

// File: rtl/sar_cfg_shadow.sv
module sar_cfg_shadow
  import sar_adc_pkg::*;
#(
  parameter logic [CFG_W-1:0] INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ch_we_i,
  input  logic [CH_FLD-1:0] ch_i,
  input  logic              full_we_i,
  input  logic [CFG_W-1:0]  full_i,
  output logic [CFG_W-1:0]  cfg_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= INIT;
    end else if (full_we_i) begin
      cfg_q <= full_i;
    end else if (ch_we_i) begin
      cfg_q[CH_LSB +: CH_FLD] <= ch_i;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/sar_spi_frame.sv
module sar_spi_frame
  import sar_adc_pkg::*;
#(
  parameter int W   = 16,
  parameter int DIV = 4,
  parameter int GAP = 500
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] tx_i,
  output logic         ready_o,
  output logic         done_o,
  output logic [W-1:0] rx_o,
  output logic         sclk_o,
  output logic         cs_no,
  output logic         mosi_o,
  input  logic         miso_i
);
  localparam int HALF   = DIV / 2;
  localparam int DIV_W  = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int EDGE_W = $clog2(2 * W);
  localparam int GAP_W  = (GAP > 1) ? $clog2(GAP) : 1;

  frame_state_e      st_q;
  logic [DIV_W-1:0]  div_q;
  logic [EDGE_W-1:0] edge_q;
  logic [GAP_W-1:0]  gap_q;
  logic [W-1:0]      tx_q, rx_q;
  logic              sclk_q, cs_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= F_IDLE;
      div_q  <= '0;
      edge_q <= '0;
      gap_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        F_IDLE: if (start_i) begin
          cs_q   <= 1'b0;
          tx_q   <= tx_i;
          div_q  <= '0;
          edge_q <= '0;
          st_q   <= F_XFER;
        end
        F_XFER: begin
          if (div_q == DIV_W'(HALF - 1)) begin
            div_q  <= '0;
            sclk_q <= ~sclk_q;
            edge_q <= edge_q + 1'b1;
            if (!sclk_q) rx_q <= {rx_q[W-2:0], miso_i};   // rising: sample
            else         tx_q <= {tx_q[W-2:0], 1'b0};     // falling: advance
            if (edge_q == EDGE_W'(2 * W - 1)) begin
              cs_q   <= 1'b1;
              done_q <= 1'b1;
              gap_q  <= '0;
              st_q   <= F_GAP;
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        F_GAP: begin
          if (gap_q == GAP_W'(GAP - 1)) st_q <= F_IDLE;
          else                          gap_q <= gap_q + 1'b1;
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end

  assign ready_o = (st_q == F_IDLE);
  assign done_o  = done_q;
  assign rx_o    = rx_q;
  assign sclk_o  = sclk_q;
  assign cs_no   = cs_q;
  assign mosi_o  = tx_q[W-1];
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int RES        = 16,
  parameter int SCLK_DIV   = 4,
  parameter int GAP_CYCLES = 500,
  parameter int REF_SEL    = 1,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [CH_W-1:0]     req_ch_i,
  input  logic                cfg_wr_i,
  input  logic [CFG_W-1:0]    cfg_data_i,
  output logic                busy_o,
  output logic                res_valid_o,
  output logic [FRAME_W-1:0]  res_data_o,
  output logic                sclk_o,
  output logic                cs_no,
  output logic                mosi_o,
  input  logic                miso_i
);
  localparam int SHIFT = FRAME_W - RES;
  localparam logic [CFG_W-1:0] BOOT_WORD = boot_cfg(3'(REF_SEL));
  localparam int BOOT_FRAMES = 5;   // one config write, two dummy conversions

  ctrl_state_e        st_q;
  logic [2:0]         frames_q;
  logic               inflight_q;
  logic [CH_W-1:0]    act_ch_q, req_ch_q;
  logic               res_valid_q;
  logic [FRAME_W-1:0] res_q;

  logic               accept_req, accept_wr, eng_start, eng_ready, eng_done;
  logic [FRAME_W-1:0] eng_rx;
  logic [CFG_W-1:0]   shadow;

  assign accept_req = (st_q == C_IDLE) && req_valid_i;
  assign accept_wr  = (st_q == C_IDLE) && !req_valid_i && cfg_wr_i;
  assign eng_start  = (st_q != C_IDLE) && eng_ready && !inflight_q;

  sar_cfg_shadow #(.INIT(BOOT_WORD)) u_shadow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ch_we_i   (accept_req),
    .ch_i      (CH_FLD'(req_ch_i)),
    .full_we_i (accept_wr),
    .full_i    (cfg_data_i),
    .cfg_o     (shadow)
  );

  sar_spi_frame #(.W(FRAME_W), .DIV(SCLK_DIV), .GAP(GAP_CYCLES)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (eng_start),
    .tx_i    ({shadow, 2'b00}),
    .ready_o (eng_ready),
    .done_o  (eng_done),
    .rx_o    (eng_rx),
    .sclk_o  (sclk_o),
    .cs_no   (cs_no),
    .mosi_o  (mosi_o),
    .miso_i  (miso_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= C_BOOT;
      frames_q    <= 3'(BOOT_FRAMES);
      inflight_q  <= 1'b0;
      act_ch_q    <= '0;
      req_ch_q    <= '0;
      res_valid_q <= 1'b0;
      res_q       <= '0;
    end else begin
      res_valid_q <= 1'b0;
      if (eng_start) inflight_q <= 1'b1;
      if (st_q == C_IDLE) begin
        if (accept_req) begin
          req_ch_q <= req_ch_i;
          frames_q <= (req_ch_i == act_ch_q) ? 3'd2 : 3'd3;
          st_q     <= C_RUN;
        end else if (accept_wr) begin
          act_ch_q <= cfg_data_i[CH_LSB +: CH_W];
          frames_q <= 3'd1;
          st_q     <= C_WRITE;
        end
      end else if (eng_done) begin
        inflight_q <= 1'b0;
        frames_q   <= frames_q - 1'b1;
        if (frames_q == 3'd1) begin
          st_q <= C_IDLE;
          if (st_q == C_RUN) begin
            res_valid_q <= 1'b1;
            res_q       <= eng_rx >> SHIFT;
            act_ch_q    <= req_ch_q;
          end
        end
      end
    end
  end

  assign busy_o      = (st_q != C_IDLE);
  assign res_valid_o = res_valid_q;
  assign res_data_o  = res_q;
endmodule

module sar_adc_ctrl_chk #(
  parameter int RES = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        busy_o,
  input logic        res_valid_o,
  input logic [15:0] res_data_o,
  input logic        sclk_o,
  input logic        cs_no,
  input logic        mosi_o
);
  p_frame_in_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_o);
  p_sclk_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  p_mosi_settled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $rose(sclk_o)) |-> $stable(mosi_o));
  p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
  p_upper_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> ((32'(res_data_o) >> RES) == 0));
  p_valid_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !busy_o);
  p_accept_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i) |=> busy_o);
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.RES(RES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .busy_o      (busy_o),
  .res_valid_o (res_valid_o),
  .res_data_o  (res_data_o),
  .sclk_o      (sclk_o),
  .cs_no       (cs_no),
  .mosi_o      (mosi_o)
);

// File: tb/sim_sar_adc_ctrl.sv
module sim_sar_adc_ctrl;
  localparam int RES = 14;
  localparam int GAP = 12;
  localparam int DIV = 4;
  localparam int REFC = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, cfg_wr = 1'b0;
  logic [2:0] req_ch = '0;
  logic [13:0] cfg_data = '0;
  logic busy, res_valid, sclk, cs_n, mosi, miso;
  logic [15:0] res_data;

  always #2 clk = ~clk;   // 250 MHz

  sar_adc_ctrl #(.NUM_CH(8), .RES(RES), .SCLK_DIV(DIV), .GAP_CYCLES(GAP), .REF_SEL(REFC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ch_i(req_ch),
    .cfg_wr_i(cfg_wr), .cfg_data_i(cfg_data), .busy_o(busy), .res_valid_o(res_valid),
    .res_data_o(res_data), .sclk_o(sclk), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso));

  int vectors = 0, fails = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // converter model: result of a frame is the conversion set up two frames earlier
  logic [15:0] cfg_log [0:1023];
  logic [15:0] deliv [0:1023];
  logic [15:0] rx_sh, out_sh, conv1 = 16'hffff, conv2 = 16'hffff;
  logic [2:0]  cur_ch = 3'd7;
  int fc = 0, bits = 0, bad_bits = 0, hi_cnt = 0, min_gap = 1 << 30;
  bit in_frame = 0;

  assign miso = out_sh[15];

  always @(negedge cs_n) begin
    in_frame = 1;
    out_sh = conv2;
    deliv[fc] = conv2;
    bits = 0;
    rx_sh = '0;
  end
  always @(posedge sclk) if (!cs_n) begin
    rx_sh = {rx_sh[14:0], mosi};
    bits++;
  end
  always @(negedge sclk) if (!cs_n) out_sh = out_sh << 1;
  always @(posedge cs_n) if (in_frame) begin
    in_frame = 0;
    if (bits != 16) bad_bits++;
    cfg_log[fc] = rx_sh;
    if (rx_sh[15]) cur_ch = rx_sh[11:9];
    conv2 = conv1;
    conv1 = {cur_ch, 13'($urandom)};
    fc++;
  end
  always @(posedge clk) begin
    if (cs_n) hi_cnt++;
    else if (hi_cnt != 0) begin
      if (fc > 0 && hi_cnt < min_gap) min_gap = hi_cnt;
      hi_cnt = 0;
    end
  end

  logic [13:0] shadow;
  logic [2:0]  active;

  function automatic logic [13:0] with_ch(input logic [13:0] c, input logic [2:0] ch);
    logic [13:0] r = c;
    r[9:7] = ch;
    return r;
  endfunction

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic do_req(input logic [2:0] ch, input bit poke);
    int fc0, n, expn, k;
    logic [13:0] expw;
    wait_idle();
    fc0 = fc;
    req_valid = 1'b1; req_ch = ch;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 busy after accept", busy, 1'b1);
    k = 0;
    while (!res_valid) begin
      @(negedge clk);
      k++;
      if (poke && k == 10) begin
        req_valid = 1'b1; req_ch = ch ^ 3'd1;
        cfg_wr = 1'b1; cfg_data = ~shadow;
        @(negedge clk);
        req_valid = 1'b0; cfg_wr = 1'b0;
      end
    end
    expw = with_ch(shadow, ch);
    n = fc - fc0;
    expn = (ch == active) ? 2 : 3;
    chk((expn == 2) ? "R5 frames same channel" : "R4 frames new channel", n, expn);
    chk("R6 channel-only update", cfg_log[fc-2], {expw, 2'b00});
    chk("R7 data frame repeats config", cfg_log[fc-1], cfg_log[fc-2]);
    if (n == 3) chk("R4 first config frame", cfg_log[fc-3], {expw, 2'b00});
    chk("R8 right-aligned result", res_data, 32'(deliv[fc-1] >> (16 - RES)));
    chk("R4 result channel", res_data[RES-1 -: 3], ch);
    chk("R9 busy clear with result", busy, 1'b0);
    @(negedge clk);
    chk("R8 valid is one pulse", res_valid, 1'b0);
    if (poke) chk("R9 ignored while busy", {busy, 13'(fc - fc0)}, {1'b0, 13'(n)});
    shadow = expw;
    active = ch;
  endtask

  task automatic do_wr(input logic [13:0] d);
    int fc0;
    wait_idle();
    fc0 = fc;
    cfg_wr = 1'b1; cfg_data = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk("R9 busy on write", busy, 1'b1);
    wait_idle();
    @(negedge clk);
    chk("R10 one write frame", fc - fc0, 1);
    chk("R10 full word sent", cfg_log[fc-1], {d, 2'b00});
    shadow = d;
    active = d[9:7];
  endtask

  initial begin
    logic [13:0] boot;
    void'($urandom(32'd20240611));
    boot = 14'h3C41 | 14'(REFC << 3);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 busy at reset", busy, 1'b1);
    chk("R1 idle bus at reset", {cs_n, sclk, res_valid}, 3'b100);
    wait_idle();
    chk("R1 boot frame count", fc, 5);
    for (int i = 0; i < 5; i++) chk("R1 boot word", cfg_log[i], {boot, 2'b00});
    shadow = boot;
    active = 3'd0;
    do_req(3'd0, 0);            // R5 primed channel 0
    do_req(3'd5, 0);            // R4
    do_req(3'd5, 0);            // R11 now active
    do_req(3'd7, 0);
    do_req(3'd0, 0);
    do_req(3'd3, 1);            // R9 pokes during busy
    do_wr(14'h2A5B);            // R10
    do_req(3'(14'h2A5B >> 7), 0);
    do_req(3'd6, 0);
    for (int i = 0; i < 30; i++) begin
      if ($urandom_range(0, 4) == 0) do_wr(14'($urandom) | 14'h2000);
      else do_req(3'($urandom_range(0, 7)), 0);
    end
    chk("R3 minimum gap", 32'(min_gap >= GAP), 1);
    chk("R2 sixteen clocks per frame", bad_bits, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule